// File: doc/BRIEF.md
# Flash Status-Poll Completion Detector

This block sits on the host side of a flash interface. It waits for an embedded program or erase to finish. Software, or a command sequencer, issues the command writes itself. After the last command write it pulses `start_i` with three things: the operation kind, the address to poll and the word that was programmed. The block then reads that address over and over through a simple request/valid read port and inspects status bit 7 of each returned word.

For a program, the operation counts as finished once bit 7 of the read word equals bit 7 of the programmed word. For buffered programming, the poll address must be the last word written. For an erase, the operation counts as finished once bit 7 reads as 1, and the poll address must lie inside a sector chosen for erasure.

Near the end of an operation, bit 7 can switch to real data while bits 6 to 0 are still stale. For that reason the block always performs one more read after the first matching one. It reports that confirming word as the result, and for a program it flags a mismatch if that word differs from the expected one. A per-operation poll budget bounds the wait and ends it with a timeout pulse.

Top module: `poll_done_detector`

## Requirements
- R1: After reset the block is idle: `busy_o`, `rd_req_o`, `done_o`, `timeout_o` and `mismatch_o` are all 0.
- R2: `start_i` is taken only while `busy_o` is 0. A start pulse that arrives while busy changes neither the polled address, nor the operation kind, nor the number of reads, nor the outcome of the operation in flight.
- R3: Every read presents the address latched at start on `rd_addr_o`. `rd_req_o` stays high, with a stable address, until `rd_valid_i` is seen high at a clock edge, and `rd_req_o` is never high while idle.
- R4: Program (`op_erase_i`=0): a polled word whose bit 7 equals bit 7 of `expect_i` is a completion candidate. Any other word causes a further poll read.
- R5: Erase (`op_erase_i`=1): a polled word with bit 7 = 1 is a completion candidate. A word with bit 7 = 0 causes a further poll read.
- R6: After a completion candidate, exactly one confirming read is issued. `result_o` carries that confirming word while `done_o` is high, and a successful operation takes N+2 reads in total when N polls failed.
- R7: For a program, `mismatch_o` is 1 together with `done_o` exactly when the confirming word differs from `expect_i` in any bit. For an erase, `mismatch_o` is always 0, and it is never 1 without `done_o`.
- R8: If M = max(`max_polls_i`, 1) poll reads in a row fail, `timeout_o` is raised after the M-th one, with no confirming read and no `done_o`.
- R9: `done_o` and `timeout_o` are one-cycle pulses, never both high together. The cycle after either pulse the block is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin polling (used only while idle) |
| op_erase_i | input | 1 | 1 = erase poll, 0 = program poll |
| addr_i | input | ADDR_W | Address to poll |
| expect_i | input | DATA_W | Word that was programmed |
| max_polls_i | input | CNT_W | Poll budget; 0 behaves as 1 |
| rd_req_o | output | 1 | Read request, held until accepted |
| rd_addr_o | output | ADDR_W | Read address |
| rd_valid_i | input | 1 | Read data valid; completes the pending request |
| rd_data_i | input | DATA_W | Read data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mismatch_o | output | 1 | Confirming word differs from expected (program), valid with `done_o` |
| timeout_o | output | 1 | One-cycle poll-budget exhaustion pulse |
| result_o | output | DATA_W | Confirming read word, valid with `done_o` |

## Verification
The assertions assume a well-behaved read port. `rd_valid_i` must be high only in a cycle where `rd_req_o` is high, and only for one cycle per request. They also assume that `start_i` is a single-cycle pulse.

The bench's responder follows this contract. It raises `rd_valid_i` at a falling edge only while a request is pending and after a per-vector latency, and it drops `rd_valid_i` at the next falling edge. Start pulses are driven for exactly one cycle, including the pulse that is deliberately sent while busy.

// File: rtl/poll_pkg.sv
package poll_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_CHECK,
        ST_CONFIRM,
        ST_DONE,
        ST_TOUT
    } poll_state_e;

endpackage

// File: rtl/poll_match.sv
module poll_match #(
    parameter int DATA_W     = 16,
    parameter int STATUS_BIT = 7
) (
    input  logic              erase_i,
    input  logic [DATA_W-1:0] sample_i,
    input  logic [DATA_W-1:0] ref_i,
    output logic              bit_hit_o,
    output logic              word_eq_o
);

    logic prog_hit;

    always_comb begin
        prog_hit  = (sample_i[STATUS_BIT] == ref_i[STATUS_BIT]);
        bit_hit_o = erase_i ? sample_i[STATUS_BIT] : prog_hit;
        word_eq_o = (sample_i == ref_i);
    end

endmodule

// File: rtl/poll_counter.sv
module poll_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic [CNT_W-1:0] limit_i,
    input  logic             inc_i,
    output logic             expired_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] limit;
    } cnt_regs_t;

    cnt_regs_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (clear_i) begin
            c_d.cnt   = '0;
            c_d.limit = limit_i;
        end else if (inc_i) begin
            c_d.cnt = c_q.cnt + 1'b1;
        end
        expired_o = ({1'b0, c_q.cnt} + 1'b1) >= {1'b0, c_q.limit};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    // a failing poll is only counted while the budget still allows it
    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i |-> ((c_q.cnt < c_q.limit) || (c_q.cnt == '0)));

endmodule

// File: rtl/poll_done_detector.sv
module poll_done_detector #(
    parameter int ADDR_W     = 24,
    parameter int DATA_W     = 16,
    parameter int CNT_W      = 16,
    parameter int STATUS_BIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              op_erase_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] expect_i,
    input  logic [CNT_W-1:0]  max_polls_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_valid_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              mismatch_o,
    output logic              timeout_o,
    output logic [DATA_W-1:0] result_o
);
    import poll_pkg::*;

    typedef struct packed {
        poll_state_e       st;
        logic              erase;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] ref_word;
        logic [DATA_W-1:0] samp;
    } regs_t;

    regs_t r_d, r_q;
    logic  hit, word_eq, expired, cnt_clr, cnt_inc;

    poll_match #(
        .DATA_W     (DATA_W),
        .STATUS_BIT (STATUS_BIT)
    ) u_match (
        .erase_i   (r_q.erase),
        .sample_i  (r_q.samp),
        .ref_i     (r_q.ref_word),
        .bit_hit_o (hit),
        .word_eq_o (word_eq)
    );

    poll_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (cnt_clr),
        .limit_i   (max_polls_i),
        .inc_i     (cnt_inc),
        .expired_o (expired)
    );

    always_comb begin
        r_d     = r_q;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st       = ST_READ;
                    r_d.erase    = op_erase_i;
                    r_d.addr     = addr_i;
                    r_d.ref_word = expect_i;
                    cnt_clr      = 1'b1;
                end
            end
            ST_READ: begin
                if (rd_valid_i) begin
                    r_d.samp = rd_data_i;
                    r_d.st   = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (hit) begin
                    r_d.st = ST_CONFIRM;
                end else begin
                    cnt_inc = 1'b1;
                    r_d.st  = expired ? ST_TOUT : ST_READ;
                end
            end
            ST_CONFIRM: begin
                if (rd_valid_i) begin
                    r_d.samp = rd_data_i;
                    r_d.st   = ST_DONE;
                end
            end
            ST_DONE: r_d.st = ST_IDLE;
            ST_TOUT: r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign rd_req_o   = (r_q.st == ST_READ) || (r_q.st == ST_CONFIRM);
    assign rd_addr_o  = r_q.addr;
    assign busy_o     = (r_q.st != ST_IDLE);
    assign done_o     = (r_q.st == ST_DONE);
    assign timeout_o  = (r_q.st == ST_TOUT);
    assign mismatch_o = done_o && !r_q.erase && !word_eq;
    assign result_o   = r_q.samp;

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_valid_i) |=> rd_req_o);

    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_valid_i) |=> $stable(rd_addr_o));

    assert_no_idle_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> busy_o);

    assert_start_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(rd_addr_o));

    assert_mismatch_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch_o |-> done_o);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    assert_tout_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |=> (!timeout_o && !busy_o));

    assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && timeout_o));

    assert_confirm_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(rd_req_o && rd_valid_i));

endmodule

// File: tb/poll_done_detector_test.sv
module poll_done_detector_test;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 24;
    localparam int DW = 16;
    localparam int CW = 16;

    typedef struct packed {
        logic          erase;
        logic [AW-1:0] addr;
        logic [DW-1:0] ref_word;
        logic [CW-1:0] maxp;
        logic [7:0]    nbusy;
        logic [3:0]    lat;
        logic [DW-1:0] confirm;
        logic [1:0]    outcome;  // 0 done, 1 mismatch, 2 timeout
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 24'h000100, 16'h1234, 16'd8,  8'd0, 4'd0, 16'h1234, 2'd0},
        '{1'b0, 24'h00ABCD, 16'h00FF, 16'd8,  8'd3, 4'd2, 16'h00FF, 2'd0},
        '{1'b0, 24'h123456, 16'hBEEF, 16'd10, 8'd5, 4'd1, 16'hBEEE, 2'd1},
        '{1'b1, 24'h200000, 16'h0000, 16'd6,  8'd2, 4'd0, 16'hFFFF, 2'd0},
        '{1'b1, 24'h3FFFFE, 16'h0000, 16'd4,  8'd4, 4'd1, 16'hFFFF, 2'd2},
        '{1'b0, 24'h000002, 16'h8001, 16'd0,  8'd1, 4'd0, 16'h8001, 2'd2},
        '{1'b0, 24'h0F0F0F, 16'h7F00, 16'd1,  8'd0, 4'd3, 16'h7F00, 2'd0},
        '{1'b1, 24'hABCDEF, 16'h0000, 16'd3,  8'd2, 4'd0, 16'h1234, 2'd0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          op_erase = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] exp_w = '0;
    logic [CW-1:0] maxp = '0;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic          rd_valid = 1'b0;
    logic [DW-1:0] rd_data = '0;
    logic          busy, done, mismatch, tout;
    logic [DW-1:0] result;

    int   checks = 0;
    int   fails = 0;
    int   idx = 0;
    int   wc = 0;
    int   nreads = 0;
    int   addr_err = 0;
    vec_t cur;

    always #(CLK_PERIOD/2) clk = ~clk;

    poll_done_detector #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .op_erase_i(op_erase),
        .addr_i(addr), .expect_i(exp_w), .max_polls_i(maxp),
        .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_valid_i(rd_valid),
        .rd_data_i(rd_data), .busy_o(busy), .done_o(done),
        .mismatch_o(mismatch), .timeout_o(tout), .result_o(result)
    );

    function automatic logic [DW-1:0] word_for(input int i);
        logic [DW-1:0] w;
        if (i < int'(cur.nbusy)) begin
            // not finished: program shows inverted bit 7, erase shows 0
            w = cur.erase ? 16'h3C4B : (cur.ref_word ^ 16'h5A80);
        end else if (i == int'(cur.nbusy)) begin
            // bit 7 already final, low bits still stale
            w = cur.erase ? 16'h00A5 : (cur.ref_word ^ 16'h0033);
        end else begin
            w = cur.confirm;
        end
        return w;
    endfunction

    // read responder, driven away from the active edge
    always @(negedge clk) begin
        if (rd_valid) begin
            rd_valid = 1'b0;
            idx++;
            wc = 0;
        end else if (rd_req) begin
            if (wc >= int'(cur.lat)) begin
                rd_valid = 1'b1;
                rd_data  = word_for(idx);
            end else begin
                wc++;
            end
        end
    end

    always @(posedge clk) begin
        if (rd_req && rd_valid) begin
            nreads++;
            if (rd_addr !== cur.addr) addr_err++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic launch(input vec_t v);
        @(negedge clk);
        cur = v; idx = 0; wc = 0; nreads = 0; addr_err = 0;
        op_erase = v.erase; addr = v.addr; exp_w = v.ref_word; maxp = v.maxp;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic finish_op(input vec_t v);
        int lim;
        int exp_reads;
        logic seen;
        seen = 1'b0;
        lim = (v.maxp == 0) ? 1 : int'(v.maxp);
        for (int c = 0; c < 3000; c++) begin
            @(posedge clk); #1;
            if (done || tout) begin seen = 1'b1; break; end
        end
        check("R9 outcome seen", 32'(seen), 32'd1);
        if (v.outcome == 2'd2) begin
            check("R8 timeout", 32'(tout), 32'd1);
            check("R8 no done", 32'(done), 32'd0);
            exp_reads = lim;
        end else begin
            check(v.erase ? "R5 done" : "R4 done", 32'(done), 32'd1);
            check("R7 mismatch", 32'(mismatch), 32'(v.outcome == 2'd1));
            check("R6 result", 32'(result), 32'(v.confirm));
            exp_reads = int'(v.nbusy) + 2;
        end
        check("R6/R8 read count", 32'(nreads), 32'(exp_reads));
        check("R3 address", 32'(addr_err), 32'd0);
        @(posedge clk); #1;
        check("R9 pulse ends", 32'({done, tout, busy}), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        cur = VECS[0];
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        check("R1 reset outputs", 32'({busy, rd_req, done, tout, mismatch}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", 32'({busy, rd_req}), 32'd0);

        for (int i = 0; i < NV; i++) begin
            launch(VECS[i]);
            finish_op(VECS[i]);
        end

        // R2: start while busy is ignored
        begin
            vec_t v;
            v = '{1'b0, 24'h055AA5, 16'h0080, 16'd20, 8'd6, 4'd2, 16'h0080, 2'd0};
            launch(v);
            repeat (4) @(negedge clk);
            op_erase = 1'b1; addr = 24'hFFFFFF; exp_w = 16'h0000; maxp = 16'd1;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check("R2 busy kept", 32'(busy), 32'd1);
            check("R2 address kept", 32'(rd_addr), 32'(v.addr));
            finish_op(v);
        end

        // R7 corner: program confirm differs only in bit 0
        begin
            vec_t v;
            v = '{1'b0, 24'h000010, 16'h00F0, 16'd2, 8'd1, 4'd0, 16'h00F1, 2'd1};
            launch(v);
            finish_op(v);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule